// File: doc/BRIEF.md
# Dual-Page Shared Translation Buffer

This block turns a virtual address and an address-space identifier into a physical address for both instruction fetches and data accesses. It holds one array of fully associative entries. Every entry covers a pair of neighbouring virtual pages and holds a separate physical frame, valid bit and caching choice for each page of the pair. A per-entry size code selects one of seven page sizes, from 4 KB to 16 MB in factors of four. The size code moves the bit that chooses between the two pages of the pair, and it sets which virtual tag bits take part in the compare.

The lookup is purely combinational, so it can run in the same cycle as a cache access. An entry is loaded through a synchronous write port, addressed by index. The lookup reports one of three outcomes: a hit, a miss, or a fault when the matching entry's selected page is marked not valid. It also drives the physical address, a write-back/write-through flag, and the index of the winning entry. When more than one entry matches, the block raises a flag and the lowest index wins.

Top module: `dual_page_tlb`

## Requirements
- R1: After reset every entry is empty, so any lookup reports a miss with a zero physical address.
- R2: An entry matches a request only when its stored tag equals the virtual address above the pair boundary, its identifier condition holds, and at least one of its two pages is valid; an entry with both pages invalid never matches.
- R3: Size code s (0 to 6) gives pages of 4 KB times 4^s; tag bits for virtual bits below 13+2s are ignored, bit 13+2s and above are compared, and codes 7 behave as code 6.
- R4: Virtual bit 12+2s selects the page inside the pair: 0 picks the even mapping, 1 the odd mapping.
- R5: On a hit the physical address is the selected frame number shifted left by 12, with its lowest 12+2s bits replaced by the same virtual address bits.
- R6: On a hit `lk_wb` carries the selected page's caching bit (1 write-back, 0 write-through); on any other outcome `lk_pa` and `lk_wb` are zero.
- R7: A match whose selected page is not valid raises `lk_invalid` and neither `lk_hit` nor `lk_miss`.
- R8: An entry with its global bit set matches under any identifier; without it the identifier must be equal.
- R9: When several entries match, `lk_multi` is raised and the lowest-index match drives every other output, including `lk_index`.
- R10: A write whose index is not below the entry count changes no entry.
- R11: With `lk_req` high exactly one of `lk_hit`, `lk_miss`, `lk_invalid` is high; with `lk_req` low all flags, `lk_pa`, `lk_wb` and `lk_index` are zero.
- R12: A write takes effect at the clock edge that samples it, and the array does not change between writes, so an unchanged request gives unchanged results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn2 | input | VA_W-13 | Virtual tag (address bits above the 8 KB pair) |
| wr_asid | input | ASID_W | Identifier stored with the entry |
| wr_global | input | 1 | Entry ignores the identifier |
| wr_size | input | 3 | Page size code |
| wr_pfn_even | input | PA_W-12 | Frame number of the even page |
| wr_v_even | input | 1 | Even page valid |
| wr_wb_even | input | 1 | Even page write-back (1) or write-through (0) |
| wr_pfn_odd | input | PA_W-12 | Frame number of the odd page |
| wr_v_odd | input | 1 | Odd page valid |
| wr_wb_odd | input | 1 | Odd page write-back (1) or write-through (0) |
| lk_hit | output | 1 | Translation found on a valid page |
| lk_miss | output | 1 | No entry matches |
| lk_invalid | output | 1 | Matching entry, selected page not valid |
| lk_multi | output | 1 | More than one entry matches |
| lk_pa | output | PA_W | Physical address |
| lk_wb | output | 1 | Caching choice of the translated page |
| lk_index | output | IDX_W | Index of the winning entry |

## Verification
The checker watches on every cycle that the three outcome flags are exclusive and complete, that an idle port drives zeros, and that a hit keeps the 4 KB offset. It also checks that a miss never comes with a multiple-match flag, and that the results stay put while neither the request nor the array changes. Whether the tag mask, the pair-bit position, the frame splice and the identifier rule give the right address under each page size can only be shown by the directed scenarios. The same holds for lowest-index priority and for writes that should be dropped. Each scenario loads known entries and compares every output against hand-derived values.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
   // smallest page is 2**BASE_SHIFT bytes; each size step multiplies by 2**STEP
   localparam int BASE_SHIFT = 12;
   localparam int STEP       = 2;
   localparam int SIZE_W     = 3;
   localparam int MAX_CODE   = 6;

   function automatic logic [SIZE_W-1:0] clamp_code(input logic [SIZE_W-1:0] code);
      return (int'(code) > MAX_CODE) ? SIZE_W'(MAX_CODE) : code;
   endfunction

   // bit position that picks the even or odd page of a pair
   function automatic int pair_bit(input logic [SIZE_W-1:0] code);
      return BASE_SHIFT + STEP * int'(clamp_code(code));
   endfunction
endpackage

// File: rtl/dpt_entry.sv
module dpt_entry
   import dpt_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 36,
   parameter int ASID_W = 8,
   localparam int VPN2_W = VA_W - BASE_SHIFT - 1,
   localparam int PFN_W  = PA_W - BASE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [VPN2_W-1:0] w_vpn2,
   input  logic [ASID_W-1:0] w_asid,
   input  logic              w_global,
   input  logic [SIZE_W-1:0] w_size,
   input  logic [PFN_W-1:0]  w_pfn_e,
   input  logic              w_v_e,
   input  logic              w_wb_e,
   input  logic [PFN_W-1:0]  w_pfn_o,
   input  logic              w_v_o,
   input  logic              w_wb_o,
   input  logic [VA_W-1:0]   q_va,
   input  logic [ASID_W-1:0] q_asid,
   output logic              match,
   output logic [PFN_W-1:0]  sel_pfn,
   output logic              sel_v,
   output logic              sel_wb,
   output logic [SIZE_W-1:0] sel_code
);
   typedef struct packed {
      logic [PFN_W-1:0] pfn;
      logic             v;
      logic             wb;
   } half_t;

   logic [VPN2_W-1:0] tag_q;
   logic [ASID_W-1:0] asid_q;
   logic              glb_q;
   logic [SIZE_W-1:0] size_q;
   half_t             even_q, odd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q  <= '0;
         asid_q <= '0;
         glb_q  <= 1'b0;
         size_q <= '0;
         even_q <= '0;
         odd_q  <= '0;
      end else if (we) begin
         tag_q  <= w_vpn2;
         asid_q <= w_asid;
         glb_q  <= w_global;
         size_q <= w_size;
         even_q <= '{pfn: w_pfn_e, v: w_v_e, wb: w_wb_e};
         odd_q  <= '{pfn: w_pfn_o, v: w_v_o, wb: w_wb_o};
      end
   end

   logic [VPN2_W-1:0] tag_mask;
   logic              odd_sel;
   logic              tag_eq;
   logic              id_ok;

   always_comb begin
      sel_code = clamp_code(size_q);
      for (int i = 0; i < VPN2_W; i++)
         tag_mask[i] = (i >= STEP * int'(sel_code));
      tag_eq  = (((tag_q ^ q_va[VA_W-1:BASE_SHIFT+1]) & tag_mask) == '0);
      id_ok   = glb_q || (asid_q == q_asid);
      odd_sel = q_va[pair_bit(size_q)];
      match   = (even_q.v || odd_q.v) && tag_eq && id_ok;
      sel_pfn = odd_sel ? odd_q.pfn : even_q.pfn;
      sel_v   = odd_sel ? odd_q.v   : even_q.v;
      sel_wb  = odd_sel ? odd_q.wb  : even_q.wb;
   end
endmodule

// File: rtl/dpt_prio.sv
module dpt_prio #(
   parameter int N = 48,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic          multi,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (req[i]) idx = IW'(i);
      any   = |req;
      multi = ($countones(req) > 1);
   end
endmodule

// File: rtl/dual_page_tlb.sv
module dual_page_tlb
   import dpt_pkg::*;
#(
   parameter int ENTRIES = 48,
   parameter int VA_W    = 32,
   parameter int PA_W    = 36,
   parameter int ASID_W  = 8,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int VPN2_W = VA_W - BASE_SHIFT - 1,
   localparam int PFN_W  = PA_W - BASE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [2:0]        wr_size,
   input  logic [PFN_W-1:0]  wr_pfn_even,
   input  logic              wr_v_even,
   input  logic              wr_wb_even,
   input  logic [PFN_W-1:0]  wr_pfn_odd,
   input  logic              wr_v_odd,
   input  logic              wr_wb_odd,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_invalid,
   output logic              lk_multi,
   output logic [PA_W-1:0]   lk_pa,
   output logic              lk_wb,
   output logic [IDX_W-1:0]  lk_index
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("dual_page_tlb: ENTRIES must be at least 2");
   end
   if (VA_W < BASE_SHIFT + STEP * MAX_CODE + 2) begin : g_bad_va
      $error("dual_page_tlb: VA_W too small for the largest page pair");
   end
   if (PA_W < BASE_SHIFT + STEP * MAX_CODE + 1) begin : g_bad_pa
      $error("dual_page_tlb: PA_W too small for the largest page");
   end
   if (ASID_W < 1) begin : g_bad_asid
      $error("dual_page_tlb: ASID_W must be positive");
   end

   logic [ENTRIES-1:0] e_match;
   logic [PFN_W-1:0]   e_pfn  [ENTRIES];
   logic               e_v    [ENTRIES];
   logic               e_wb   [ENTRIES];
   logic [SIZE_W-1:0]  e_code [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      dpt_entry #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (wr_en && (32'(wr_idx) == g)),
         .w_vpn2   (wr_vpn2),
         .w_asid   (wr_asid),
         .w_global (wr_global),
         .w_size   (wr_size),
         .w_pfn_e  (wr_pfn_even),
         .w_v_e    (wr_v_even),
         .w_wb_e   (wr_wb_even),
         .w_pfn_o  (wr_pfn_odd),
         .w_v_o    (wr_v_odd),
         .w_wb_o   (wr_wb_odd),
         .q_va     (lk_va),
         .q_asid   (lk_asid),
         .match    (e_match[g]),
         .sel_pfn  (e_pfn[g]),
         .sel_v    (e_v[g]),
         .sel_wb   (e_wb[g]),
         .sel_code (e_code[g])
      );
   end

   logic             found, several;
   logic [IDX_W-1:0] win;

   dpt_prio #(.N(ENTRIES)) u_prio (
      .req   (e_match),
      .any   (found),
      .multi (several),
      .idx   (win)
   );

   logic [PA_W+VA_W-1:0] va_ext;
   logic [PA_W-1:0]      frame_base;
   logic [PA_W-1:0]      pa_calc;
   int                   keep_lo;

   always_comb begin
      va_ext     = {{PA_W{1'b0}}, lk_va};
      frame_base = {e_pfn[win], {BASE_SHIFT{1'b0}}};
      keep_lo    = pair_bit(e_code[win]);
      for (int k = 0; k < PA_W; k++)
         pa_calc[k] = (k < keep_lo) ? va_ext[k] : frame_base[k];

      lk_miss    = lk_req && !found;
      lk_hit     = lk_req && found && e_v[win];
      lk_invalid = lk_req && found && !e_v[win];
      lk_multi   = lk_req && several;
      lk_pa      = lk_hit ? pa_calc : '0;
      lk_wb      = lk_hit && e_wb[win];
      lk_index   = (lk_req && found) ? win : '0;
   end
endmodule

// File: rtl/dpt_chk.sv
module dpt_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 36,
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_req,
   input logic [VA_W-1:0]  lk_va,
   input logic [7:0]       lk_asid_lo,
   input logic             wr_en,
   input logic             lk_hit,
   input logic             lk_miss,
   input logic             lk_invalid,
   input logic             lk_multi,
   input logic [PA_W-1:0]  lk_pa,
   input logic             lk_wb,
   input logic [IDX_W-1:0] lk_index
);
   assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |-> $countones({lk_hit, lk_miss, lk_invalid}) == 1);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> !lk_hit && !lk_miss && !lk_invalid && !lk_multi
                  && lk_pa == '0 && !lk_wb && lk_index == '0);

   assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_pa[11:0] == lk_va[11:0]);

   assert_nohit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_pa == '0 && !lk_wb);

   assert_multi_not_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi |-> !lk_miss);

   assert_stable_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && $past(lk_req) && !$past(wr_en) && $stable(lk_va) && $stable(lk_asid_lo))
      |-> $stable(lk_hit) && $stable(lk_invalid) && $stable(lk_pa) && $stable(lk_index));
endmodule

bind dual_page_tlb dpt_chk #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_req     (lk_req),
   .lk_va      (lk_va),
   .lk_asid_lo (8'(lk_asid)),
   .wr_en      (wr_en),
   .lk_hit     (lk_hit),
   .lk_miss    (lk_miss),
   .lk_invalid (lk_invalid),
   .lk_multi   (lk_multi),
   .lk_pa      (lk_pa),
   .lk_wb      (lk_wb),
   .lk_index   (lk_index)
);

// File: tb/sim_dual_page_tlb.sv
`timescale 1ns/1ps
module sim_dual_page_tlb;
   localparam int ENTRIES = 48;
   localparam int VA_W = 32, PA_W = 36, ASID_W = 8;
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int VPN2_W = VA_W - 13, PFN_W = PA_W - 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_req = 1'b0;
   logic [VA_W-1:0] lk_va = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic wr_en = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0;
   logic [VPN2_W-1:0] wr_vpn2 = '0;
   logic [ASID_W-1:0] wr_asid = '0;
   logic wr_global = 1'b0;
   logic [2:0] wr_size = '0;
   logic [PFN_W-1:0] wr_pfn_even = '0, wr_pfn_odd = '0;
   logic wr_v_even = 1'b0, wr_wb_even = 1'b0, wr_v_odd = 1'b0, wr_wb_odd = 1'b0;
   logic lk_hit, lk_miss, lk_invalid, lk_multi, lk_wb;
   logic [PA_W-1:0] lk_pa;
   logic [IDX_W-1:0] lk_index;

   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   dual_page_tlb #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u0 (.*);

   task automatic load(input int idx, input logic [VA_W-1:0] va_base, input logic [VPN2_W-1:0] junk,
                       input logic [ASID_W-1:0] asid, input logic glb, input logic [2:0] sz,
                       input logic [PFN_W-1:0] pe, input logic ve, input logic we_,
                       input logic [PFN_W-1:0] po, input logic vo, input logic wo);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDX_W'(idx);
      wr_vpn2 = va_base[VA_W-1:13] | junk; wr_asid = asid; wr_global = glb; wr_size = sz;
      wr_pfn_even = pe; wr_v_even = ve; wr_wb_even = we_;
      wr_pfn_odd = po; wr_v_odd = vo; wr_wb_odd = wo;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic probe(input string req, input logic r, input logic [VA_W-1:0] va,
                        input logic [ASID_W-1:0] asid,
                        input logic eh, input logic em, input logic ei, input logic emu,
                        input logic [PA_W-1:0] epa, input logic ewb, input logic [IDX_W-1:0] eidx);
      @(negedge clk);
      lk_req = r; lk_va = va; lk_asid = asid;
      #1;
      checks++;
      if ({lk_hit, lk_miss, lk_invalid, lk_multi, lk_pa, lk_wb, lk_index} !==
          {eh, em, ei, emu, epa, ewb, eidx}) begin
         fails++;
         $display("FAIL %s va=%h: got hit=%b miss=%b inv=%b multi=%b pa=%h wb=%b idx=%0d, expected hit=%b miss=%b inv=%b multi=%b pa=%h wb=%b idx=%0d",
                  req, va, lk_hit, lk_miss, lk_invalid, lk_multi, lk_pa, lk_wb, lk_index,
                  eh, em, ei, emu, epa, ewb, eidx);
      end
   endtask

   task automatic t_reset;
      probe("R1", 1, 32'h0000_0000, 8'h00, 0, 1, 0, 0, '0, 0, '0);
      probe("R11", 0, 32'h0000_0000, 8'h00, 0, 0, 0, 0, '0, 0, '0);
   endtask

   task automatic t_basic;
      load(0, 32'h0040_0000, '0, 8'h05, 0, 3'd0, 24'h000123, 1, 1, 24'h000456, 1, 0);
      probe("R2 R4 R5 R6 even", 1, 32'h0040_0ABC, 8'h05, 1, 0, 0, 0, 36'h000123ABC, 1, 6'd0);
      probe("R4 R6 odd", 1, 32'h0040_1ABC, 8'h05, 1, 0, 0, 0, 36'h000456ABC, 0, 6'd0);
      probe("R8 asid mismatch", 1, 32'h0040_0ABC, 8'h06, 0, 1, 0, 0, '0, 0, '0);
   endtask

   task automatic t_global;
      load(1, 32'h0080_0000, '0, 8'h00, 1, 3'd0, 24'h000777, 1, 0, 24'h000888, 0, 1);
      probe("R8 global", 1, 32'h0080_0010, 8'h33, 1, 0, 0, 0, 36'h000777010, 0, 6'd1);
      probe("R7 invalid half", 1, 32'h0080_1010, 8'h33, 0, 0, 1, 0, '0, 0, 6'd1);
   endtask

   task automatic t_sizes;
      // 16 MB pages: tag junk below bit 25 must be ignored, frame bits below 24 replaced
      load(2, 32'h0400_0000, 19'h00ABC, 8'h01, 0, 3'd6, 24'h012345, 1, 0, 24'h0AB000, 1, 1);
      probe("R3 R4 R5 16M odd", 1, 32'h0512_3456, 8'h01, 1, 0, 0, 0, 36'h0AB123456, 1, 6'd2);
      probe("R3 R5 16M even", 1, 32'h0412_3456, 8'h01, 1, 0, 0, 0, 36'h012123456, 0, 6'd2);
      probe("R3 bit above pair compared", 1, 32'h0612_3456, 8'h01, 0, 1, 0, 0, '0, 0, '0);
      load(3, 32'h1000_0000, '0, 8'h00, 1, 3'd7, 24'h100000, 1, 1, 24'h000000, 0, 0);
      probe("R3 code7 as 16M", 1, 32'h10FF_FFFF, 8'h44, 1, 0, 0, 0, 36'h100FFFFFF, 1, 6'd3);
      // 64 KB pages (code 2): pair bit 16
      load(7, 32'h0020_0000, '0, 8'h09, 0, 3'd2, 24'h0ABCD0, 0, 0, 24'h055550, 1, 1);
      probe("R3 R4 R5 64K odd", 1, 32'h0021_ABCD, 8'h09, 1, 0, 0, 0, 36'h05555ABCD, 1, 6'd7);
      probe("R7 64K even invalid", 1, 32'h0020_ABCD, 8'h09, 0, 0, 1, 0, '0, 0, 6'd7);
   endtask

   task automatic t_multi;
      load(5, 32'h2000_0000, '0, 8'h00, 1, 3'd0, 24'h000555, 1, 0, 24'h0, 0, 0);
      load(4, 32'h2000_0000, '0, 8'h00, 1, 3'd0, 24'h000444, 1, 1, 24'h0, 0, 0);
      probe("R9 lowest wins", 1, 32'h2000_0008, 8'h00, 1, 0, 0, 1, 36'h000444008, 1, 6'd4);
   endtask

   task automatic t_ignored;
      load(50, 32'h3000_0000, '0, 8'h00, 1, 3'd0, 24'h000AAA, 1, 1, 24'h0, 0, 0);
      probe("R10 out-of-range write", 1, 32'h3000_0000, 8'h00, 0, 1, 0, 0, '0, 0, '0);
      probe("R10 entry 0 intact", 1, 32'h0040_0ABC, 8'h05, 1, 0, 0, 0, 36'h000123ABC, 1, 6'd0);
      load(6, 32'h3800_0000, '0, 8'h00, 1, 3'd0, 24'h000BBB, 0, 0, 24'h000CCC, 0, 0);
      probe("R2 both halves invalid", 1, 32'h3800_0000, 8'h00, 0, 1, 0, 0, '0, 0, '0);
   endtask

   task automatic t_rewrite;
      probe("R12 before rewrite", 1, 32'h0040_0ABC, 8'h05, 1, 0, 0, 0, 36'h000123ABC, 1, 6'd0);
      load(0, 32'h0040_0000, '0, 8'h05, 0, 3'd0, 24'h000999, 1, 0, 24'h000456, 1, 0);
      probe("R12 after rewrite", 1, 32'h0040_0ABC, 8'h05, 1, 0, 0, 0, 36'h000999ABC, 0, 6'd0);
      probe("R11 idle after hit", 0, 32'h0040_0ABC, 8'h05, 0, 0, 0, 0, '0, 0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_global();
      t_sizes();
      t_multi();
      t_ignored();
      t_rewrite();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #100000;
      checks++; fails++;
      $display("FAIL watchdog: got no completion, expected end of scenarios");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule